// File: doc/BRIEF.md
# Three-Stage Watchdog Timer Bank

A parameterised set of independent watchdog timers sharing one memory-mapped register port. Each timer counts down a 24-bit value that is loaded from a 16-bit length placed in its upper bits, with the low 8 bits cleared. A shared prescaler makes every running counter step once per `PRESCALE` clock cycles (1024 by default). When a counter runs out, the timer reloads itself from its length and moves one step along an escalation path chosen by its mode. The path can raise a core interrupt, then a one-cycle management-processor interrupt pulse, then a one-cycle system reset pulse.

Software keeps a timer from escalating by poking it. A poke reloads the counter and returns the escalation stage to the start. Core interrupt state is shared: one pending bit per timer, cleared by writing 1, and one enable bit per timer, with separate set and clear addresses. The core interrupt line is high while any timer is both pending and enabled. The management interrupt and system reset outputs are ORed over all timers.

Top module: `wdog_bank`

## Requirements
- R1: After reset, every config word reads 0 and every timer is stopped. The pending and enable bits are 0. `irq_core`, `irq_mgmt` and `sys_rst_out` are low.
- R2: The config word of timer i is at byte address 8*i. It holds mode in bits [1:0], a management-interrupt enable in bit 2, the length in bits [19:4] and the live count in bits [43:20]. The count field is read-only, and writes to it are ignored.
- R3: Writing a nonzero mode to a stopped timer (mode 0) loads its count with length*256, that is, the length in count bits [23:8] and zeros in bits [7:0].
- R4: A running timer decrements its count by one every `PRESCALE` clock cycles. A timer in mode 0 holds its count.
- R5: Writing data with bit 0 = 1 to address 0x10000 + 8*i reloads the count of timer i from its length and returns its stage to the first stage. A write there with bit 0 = 0 has no effect.
- R6: In mode 1, every expiry sets the timer's pending bit. `irq_core` is the OR over timers of pending AND enable.
- R7: A write to 0x200 clears each pending bit whose data bit is 1. A write to 0x218 sets each enable bit whose data bit is 1, and a write to 0x210 clears it. Reading 0x200 returns the pending bits, and reading 0x210 or 0x218 returns the enable bits, with bit i belonging to timer i.
- R8: In mode 2, the first expiry sets the pending bit and the second expiry gives one `irq_mgmt` pulse of one cycle. Later expiries have no effect.
- R9: In mode 3, the first two expiries act as in mode 2 (with R10 applying to the second). The third expiry gives one `sys_rst_out` pulse of one cycle, and the timer's mode then reads 0.
- R10: In mode 3 with config bit 2 = 0, the second expiry gives no `irq_mgmt` pulse. The third expiry still resets.
- R11: A config write to a running timer that changes its mode or length does not change its live count.
- R12: Every expiry reloads the count from the current length, so each stage is timed with the same interval.
- R13: Every request on the bus gets `rsp_valid` exactly one cycle later, and the read data arrives with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 64 | Read data (0 for writes and unmapped addresses) |
| irq_core | output | 1 | Core interrupt, level |
| irq_mgmt | output | 1 | Management interrupt, one-cycle pulse |
| sys_rst_out | output | 1 | System reset request, one-cycle pulse |

## Verification
The bench attacks the escalation sequence stage by stage, with a queue of expected management and reset pulses. A design that fires the management pulse on the wrong expiry, or resets too early, pops a mismatching or missing entry. Poking a timer right after its first expiry must restart the sequence: a design that does not clear the stage would emit a management pulse that nothing expects. The bench also writes garbage into the count field, changes the length of a running timer and writes a poke with bit 0 = 0. A design that let any of these reach the count would show a reloaded or jumped count on the next read. Finally, the bench toggles enable while the pending bit is still set, to separate interrupt masking from clearing.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  parameter int unsigned LEN_W = 16;
  parameter int unsigned CNT_W = 24;
  localparam int unsigned LOW_ZERO = CNT_W - LEN_W;
  localparam int unsigned MGMT_BIT = 2;
  localparam int unsigned LEN_LSB  = 4;
  localparam int unsigned CNT_LSB  = LEN_LSB + LEN_W;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_CORE  = 2'd1,
    MODE_MGMT  = 2'd2,
    MODE_RESET = 2'd3
  } wd_mode_e;

  typedef logic [CNT_W-1:0] wd_cnt_t;
  typedef logic [LEN_W-1:0] wd_len_t;

  // Count value loaded from a length: length in the top bits, zeros below.
  function automatic wd_cnt_t reload_of(input wd_len_t len);
    return {len, {LOW_ZERO{1'b0}}};
  endfunction

  // Layout of the readable config word.
  function automatic logic [63:0] pack_cfg(input wd_mode_e m, input logic mg,
                                           input wd_len_t l, input wd_cnt_t c);
    logic [63:0] w;
    w = '0;
    w[1:0] = m;
    w[MGMT_BIT] = mg;
    w[LEN_LSB +: LEN_W] = l;
    w[CNT_LSB +: CNT_W] = c;
    return w;
  endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned DIV = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == LAST);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     cfg_we,
  input  wd_mode_e wr_mode,
  input  logic     wr_mgmt_en,
  input  wd_len_t  wr_len,
  input  logic     poke,
  output wd_mode_e mode,
  output logic     mgmt_en,
  output wd_len_t  len,
  output wd_cnt_t  cnt,
  output logic     core_evt,
  output logic     expire,
  output logic     reload,
  output logic     mgmt_pulse,
  output logic     rst_pulse
);
  wd_mode_e   mode_q;
  logic       mgmt_en_q;
  wd_len_t    len_q;
  wd_cnt_t    cnt_q;
  logic [1:0] stage_q;
  logic       start, mgmt_fire, rst_fire;

  always_comb begin
    start     = cfg_we && (mode_q == MODE_OFF) && (wr_mode != MODE_OFF);
    expire    = tick && (mode_q != MODE_OFF) && (cnt_q == '0) && !poke;
    reload    = poke || start || expire;
    core_evt  = expire && ((mode_q == MODE_CORE) || (stage_q == 2'd0));
    mgmt_fire = expire && (stage_q == 2'd1) &&
                ((mode_q == MODE_MGMT) || ((mode_q == MODE_RESET) && mgmt_en_q));
    rst_fire  = expire && (mode_q == MODE_RESET) && (stage_q == 2'd2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_OFF;
      mgmt_en_q  <= 1'b0;
      len_q      <= '0;
      cnt_q      <= '0;
      stage_q    <= 2'd0;
      mgmt_pulse <= 1'b0;
      rst_pulse  <= 1'b0;
    end else begin
      if (cfg_we) begin
        mode_q    <= wr_mode;
        mgmt_en_q <= wr_mgmt_en;
        len_q     <= wr_len;
      end
      if (rst_fire) mode_q <= MODE_OFF;

      if (start) cnt_q <= reload_of(wr_len);
      else if (poke || expire) cnt_q <= reload_of(len_q);
      else if (tick && (mode_q != MODE_OFF)) cnt_q <= cnt_q - 1'b1;

      if (poke || start) stage_q <= 2'd0;
      else if (expire) begin
        case (mode_q)
          MODE_MGMT:  if (stage_q != 2'd2) stage_q <= stage_q + 2'd1;
          MODE_RESET: stage_q <= (stage_q == 2'd2) ? 2'd0 : stage_q + 2'd1;
          default:    stage_q <= stage_q;
        endcase
      end

      mgmt_pulse <= mgmt_fire;
      rst_pulse  <= rst_fire;
    end
  end

  assign mode    = mode_q;
  assign mgmt_en = mgmt_en_q;
  assign len     = len_q;
  assign cnt     = cnt_q;
endmodule

// File: rtl/wdog_irq.sv
module wdog_irq #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] core_evt,
  input  logic         clr_pend_we,
  input  logic         set_en_we,
  input  logic         clr_en_we,
  input  logic [N-1:0] wmask,
  output logic [N-1:0] pending,
  output logic [N-1:0] enable,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      enable  <= '0;
    end else begin
      pending <= (pending & ~(clr_pend_we ? wmask : '0)) | core_evt;
      if (set_en_we)      enable <= enable | wmask;
      else if (clr_en_we) enable <= enable & ~wmask;
    end
  end

  assign irq = |(pending & enable);
endmodule

// File: rtl/wdog_bank.sv
module wdog_bank
  import wdog_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 4,
  parameter int unsigned PRESCALE   = 1024,
  parameter int unsigned ADDR_W     = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              irq_core,
  output logic              irq_mgmt,
  output logic              sys_rst_out
);
  localparam logic [ADDR_W-1:0] PEND_ADDR   = ADDR_W'(32'h200);
  localparam logic [ADDR_W-1:0] EN_CLR_ADDR = ADDR_W'(32'h210);
  localparam logic [ADDR_W-1:0] EN_SET_ADDR = ADDR_W'(32'h218);
  localparam logic [ADDR_W-1:0] POKE_BASE   = ADDR_W'(32'h10000);

  logic wr, tick_w;
  logic [NUM_TIMERS-1:0] cfg_hit, poke_hit;
  logic [NUM_TIMERS-1:0][1:0] mode_a;
  logic [NUM_TIMERS-1:0] mgmt_a;
  logic [NUM_TIMERS-1:0][LEN_W-1:0] len_a;
  logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt_a;
  logic [NUM_TIMERS-1:0] core_a, expire_a, reload_a, mgmtp_a, rstp_a;
  logic [NUM_TIMERS-1:0] pending, enable;
  logic [63:0] rd;
  logic unused_wdata;

  assign wr = req_valid && req_write;
  assign unused_wdata = ^{req_wdata[63:LEN_LSB+LEN_W], req_wdata[3]};

  wdog_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick(tick_w)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    assign cfg_hit[i]  = (req_addr == ADDR_W'(8 * i));
    assign poke_hit[i] = (req_addr == POKE_BASE + ADDR_W'(8 * i));

    wdog_timer u_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick_w),
      .cfg_we(wr && cfg_hit[i]),
      .wr_mode(wd_mode_e'(req_wdata[1:0])),
      .wr_mgmt_en(req_wdata[MGMT_BIT]),
      .wr_len(req_wdata[LEN_LSB +: LEN_W]),
      .poke(wr && poke_hit[i] && req_wdata[0]),
      .mode(mode_a[i]), .mgmt_en(mgmt_a[i]), .len(len_a[i]), .cnt(cnt_a[i]),
      .core_evt(core_a[i]), .expire(expire_a[i]), .reload(reload_a[i]),
      .mgmt_pulse(mgmtp_a[i]), .rst_pulse(rstp_a[i])
    );
  end

  wdog_irq #(.N(NUM_TIMERS)) u_irq (
    .clk(clk), .rst_n(rst_n), .core_evt(core_a),
    .clr_pend_we(wr && req_addr == PEND_ADDR),
    .set_en_we(wr && req_addr == EN_SET_ADDR),
    .clr_en_we(wr && req_addr == EN_CLR_ADDR),
    .wmask(req_wdata[NUM_TIMERS-1:0]),
    .pending(pending), .enable(enable), .irq(irq_core)
  );

  always_comb begin
    rd = '0;
    if (req_addr == PEND_ADDR) rd[NUM_TIMERS-1:0] = pending;
    if (req_addr == EN_CLR_ADDR || req_addr == EN_SET_ADDR) rd[NUM_TIMERS-1:0] = enable;
    for (int k = 0; k < NUM_TIMERS; k++) begin
      if (cfg_hit[k]) rd = pack_cfg(wd_mode_e'(mode_a[k]), mgmt_a[k], len_a[k], cnt_a[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd : '0;
    end
  end

  assign irq_mgmt    = |mgmtp_a;
  assign sys_rst_out = |rstp_a;
endmodule

// File: rtl/wdog_bank_chk.sv
module wdog_bank_chk
  import wdog_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 4
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic rsp_valid,
  input logic irq_mgmt,
  input logic sys_rst_out,
  input logic tick,
  input logic [NUM_TIMERS-1:0] expire,
  input logic [NUM_TIMERS-1:0] reload,
  input logic [NUM_TIMERS-1:0][1:0] mode,
  input logic [NUM_TIMERS-1:0][LEN_W-1:0] len,
  input logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt,
  input logic [NUM_TIMERS-1:0] rst_evt
);
  assert_rsp_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_rst_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_out |=> !sys_rst_out);
  assert_mgmt_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mgmt |=> !irq_mgmt);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk
    assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !reload[i]) |=> $stable(cnt[i]));
    assert_stopped_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i] == 2'd0 && !reload[i]) |=> $stable(cnt[i]));
    assert_expiry_reload_R12: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] |=> (cnt[i] == reload_of($past(len[i]))));
    assert_stop_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_evt[i] |-> (mode[i] == 2'd0));
  end
endmodule

bind wdog_bank wdog_bank_chk #(.NUM_TIMERS(NUM_TIMERS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .irq_mgmt(irq_mgmt), .sys_rst_out(sys_rst_out), .tick(tick_w),
  .expire(expire_a), .reload(reload_a), .mode(mode_a), .len(len_a),
  .cnt(cnt_a), .rst_evt(rstp_a)
);

// File: tb/wdog_bank_bench.sv
module wdog_bank_bench;
  localparam int N  = 4;
  localparam int PS = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic rsp_valid, irq_core, irq_mgmt, sys_rst_out;
  logic [63:0] rsp_rdata;

  wdog_bank #(.NUM_TIMERS(N), .PRESCALE(PS)) u_wdog_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .irq_core(irq_core), .irq_mgmt(irq_mgmt),
    .sys_rst_out(sys_rst_out)
  );

  int checks = 0, fails = 0;
  int mgmt_seen = 0, rst_seen = 0;
  byte exp_q[$];
  bit done = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [63:0] cfgw(input int m, input int mg, input int l);
    return 64'(m) | (64'(mg) << 2) | (64'(l) << 4);
  endfunction

  task automatic bus_write(input logic [16:0] a, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_read(input logic [16:0] a, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid == 1'b1, "R13 rsp_valid", rsp_valid, 1);
    d = rsp_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops the expected pulse kind for every observed pulse.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (irq_mgmt) begin
        mgmt_seen++;
        check(exp_q.size() > 0 && exp_q[0] == "M", "R8/R10 unexpected mgmt pulse",
              exp_q.size() > 0 ? exp_q[0] : 0, "M");
        if (exp_q.size() > 0 && exp_q[0] == "M") void'(exp_q.pop_front());
      end
      if (sys_rst_out) begin
        rst_seen++;
        check(exp_q.size() > 0 && exp_q[0] == "R", "R9 unexpected reset pulse",
              exp_q.size() > 0 ? exp_q[0] : 0, "R");
        if (exp_q.size() > 0 && exp_q[0] == "R") void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] d;
    int c1, c2;
    idle(4);
    rst_n = 1;
    idle(2);

    // R1 reset state
    check(irq_core == 0 && irq_mgmt == 0 && sys_rst_out == 0, "R1 outputs", irq_core, 0);
    bus_read(17'h0, d);     check(d == 0, "R1 cfg0", d, 0);
    bus_read(17'h200, d);   check(d == 0, "R1 pending", d, 0);
    bus_read(17'h218, d);   check(d == 0, "R1 enable", d, 0);

    // R2 / R3: start timer 0, garbage in count field
    bus_write(17'h0, cfgw(1, 0, 1) | (64'hFFFFFF << 20));
    bus_read(17'h0, d);
    check(d[1:0] == 1 && d[19:4] == 1 && d[2] == 0, "R2 fields", d[19:0], 17);
    c1 = int'(d[43:20]);
    check(c1 <= 256 && c1 >= 250, "R3 start load", c1, 256);

    // R4 decrement rate
    idle(40);
    bus_read(17'h0, d);
    c2 = int'(d[43:20]);
    check((c1 - c2) >= 9 && (c1 - c2) <= 12, "R4 rate", c1 - c2, 10);

    // R6 core interrupt
    bus_write(17'h218, 64'h1);
    check(irq_core == 0, "R6 no irq before expiry", irq_core, 0);
    idle(1100);
    check(irq_core == 1, "R6 irq after expiry", irq_core, 1);
    bus_read(17'h200, d);   check(d[0] == 1, "R6 pending", d, 1);
    bus_read(17'h0, d);
    c1 = int'(d[43:20]);
    check(c1 >= 200 && c1 <= 256, "R12 reload after expiry", c1, 226);

    // R7 enable set/clear and pending clear
    bus_write(17'h210, 64'h1);
    check(irq_core == 0, "R7 enable clear masks", irq_core, 0);
    bus_read(17'h210, d);   check(d == 0, "R7 enable read", d, 0);
    bus_read(17'h200, d);   check(d[0] == 1, "R7 pending kept", d, 1);
    bus_write(17'h218, 64'h1);
    check(irq_core == 1, "R7 enable set", irq_core, 1);
    bus_write(17'h200, 64'h1);
    check(irq_core == 0, "R7 pending w1c", irq_core, 0);
    bus_read(17'h200, d);   check(d == 0, "R7 pending read", d, 0);

    // R5 poke with bit0 = 0 ignored, bit0 = 1 reloads
    bus_read(17'h0, d);     c1 = int'(d[43:20]);
    bus_write(17'h10000, 64'h2);
    bus_read(17'h0, d);     c2 = int'(d[43:20]);
    check(c2 <= c1, "R5 poke data 0 ignored", c2, c1);
    bus_write(17'h10000, 64'h1);
    bus_read(17'h0, d);     c2 = int'(d[43:20]);
    check(c2 >= 254 && c2 <= 256, "R5 poke reload", c2, 256);

    // R11 length change while running leaves count
    idle(40);
    bus_write(17'h0, cfgw(1, 0, 2));
    bus_read(17'h0, d);
    check(int'(d[43:20]) <= 256 && d[19:4] == 2, "R11 count untouched", d[43:20], 246);

    // R4 mode 0 holds
    bus_write(17'h0, cfgw(0, 0, 2));
    bus_read(17'h0, d);     c1 = int'(d[43:20]);
    idle(100);
    bus_read(17'h0, d);     c2 = int'(d[43:20]);
    check(c1 == c2, "R4 stopped holds", c2, c1);

    // R5 poke returns stage to first (timer 3, mode 2)
    bus_write(17'h18, cfgw(2, 0, 1));
    idle(1100);
    bus_read(17'h200, d);   check(d[3] == 1, "R8 first expiry pending", d, 8);
    bus_write(17'h10018, 64'h1);
    bus_write(17'h200, 64'h8);
    idle(1100);
    bus_read(17'h200, d);   check(d[3] == 1, "R5 stage reset by poke", d, 8);
    check(mgmt_seen == 0, "R5 no mgmt after poke", mgmt_seen, 0);
    bus_write(17'h18, cfgw(0, 0, 1));
    bus_write(17'h200, 64'hF);

    // R8 mode 2 escalation (timer 1)
    exp_q.push_back("M");
    bus_write(17'h8, cfgw(2, 0, 1));
    idle(1100);
    bus_read(17'h200, d);   check(d[1] == 1, "R8 pending stage 1", d, 2);
    check(mgmt_seen == 0, "R8 no mgmt yet", mgmt_seen, 0);
    idle(1100);
    check(mgmt_seen == 1, "R8 mgmt on second", mgmt_seen, 1);
    idle(1100);
    check(mgmt_seen == 1 && rst_seen == 0, "R8 nothing later", mgmt_seen, 1);
    bus_write(17'h8, cfgw(0, 0, 1));

    // R9 mode 3 with mgmt enabled (timer 2)
    exp_q.push_back("M"); exp_q.push_back("R");
    bus_write(17'h10, cfgw(3, 1, 1));
    idle(2200);
    check(mgmt_seen == 2 && rst_seen == 0, "R9 mgmt before reset", mgmt_seen, 2);
    idle(1100);
    check(rst_seen == 1, "R9 reset on third", rst_seen, 1);
    bus_read(17'h10, d);    check(d[1:0] == 0, "R9 mode forced 0", d[1:0], 0);
    check(sys_rst_out == 0, "R9 reset pulse ended", sys_rst_out, 0);

    // R10 mode 3 with mgmt disabled (timer 3)
    exp_q.push_back("R");
    bus_write(17'h18, cfgw(3, 0, 1));
    idle(2200);
    check(mgmt_seen == 2 && rst_seen == 1, "R10 silent second", mgmt_seen, 2);
    idle(1100);
    check(rst_seen == 2, "R10 reset on third", rst_seen, 2);

    check(exp_q.size() == 0, "R8/R9 all expected pulses seen", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule